// File: doc/BRIEF.md
# Seven-Point 3D Stencil Engine

This block applies a weighted seven-point stencil to a three-dimensional grid of signed fixed-point samples. The grid arrives as a valid/ready stream in raster order: the I index changes fastest, then J, then K. For every cell the engine multiplies the cell itself and its six axis neighbours (one step either way along I, J and K) by seven separately programmed coefficients. It sums the seven products and emits the result on a valid/ready output stream, in the same raster order as the input.

Each cell's result depends on samples one plane ahead of it and one plane behind it. The engine therefore keeps a circular window of recent samples that spans two planes plus a margin. A result for a given cell leaves once the sample one plane after it has arrived. Cells on any face of the grid have no full neighbourhood. For those cells the engine forwards the centre sample unchanged, sign-extended, and raises a boundary flag. Because every cell of the last plane is such a face cell, the final plane drains without waiting for further input.

The coefficients and the three grid extents are loaded through a small write-only register port. The extents may be anything from 1 up to the compile-time maxima. A frame is exactly I×J×K samples long, and frames may follow each other back to back.

Top module: `stencil7_engine`

## Requirements
- R1: For an interior cell at raster index c with I-extent NI and plane size P = NI·NJ, the result is the sum of seven products: coef0·x[c], coef1·x[c−1], coef2·x[c+1], coef3·x[c−NI], coef4·x[c+NI], coef5·x[c−P] and coef6·x[c+P]. The sum is arithmetically shifted right by SHIFT (8) and its low OUT_W (24) bits are output. Register address a (0..6) writes coefficient a.
- R2: A cell with i, j or k equal to 0 or to its extent minus one outputs its centre sample sign-extended to OUT_W bits with out_boundary = 1. Interior cells output out_boundary = 0.
- R3: Each frame yields exactly NI·NJ·NK results, in raster order. No result appears without a matching input cell.
- R4: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_data and out_boundary hold their values. No result is lost or duplicated under any pattern of output backpressure or input gaps.
- R5: Input takes at most one frame of samples ahead of the output side. Two frames streamed back to back both produce correct results.
- R6: Register addresses 7, 8 and 9 set the I, J and K extents. A write is taken only while the engine is idle (no frame in progress) and only for a value from 1 to the maximum extent. Any other such write leaves the extents unchanged.
- R7: After reset out_valid is 0, in_ready is 1, all coefficients are 0 and every extent equals its maximum.
- R8: Writes to register addresses 10 to 15 change nothing.
- R9: The seven-term sum never overflows the internal accumulator, even with every sample and every coefficient at −32768.
- R10: A grid whose extent along some axis is at most 2 has every cell on the boundary. Every result of such a grid is the forwarded centre sample with the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address (0..6 coefficients, 7..9 extents) |
| cfg_wdata | input | SAMPLE_W | Register write data |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Engine accepts a sample this cycle |
| in_data | input | SAMPLE_W | Signed input sample |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer accepts the result |
| out_data | output | OUT_W | Signed result |
| out_boundary | output | 1 | Result belongs to a face cell |

## Verification
The hardest situation to reach is the point where the sample window is nearly full while the output is stalled. In that state the write pointer runs right up to the oldest sample that a pending interior result still needs. The bench reaches it by holding out_ready low for long random stretches while it keeps offering input. It also streams two frames back to back, so that a new frame starts loading while the previous frame's last plane is still draining. A register write to an extent is issued mid-frame, so the rule that writes are taken only when idle is checked against a live pipeline.

// File: rtl/stencil_pkg.sv
package stencil_pkg;
  localparam int NPTS = 7;

  // Point order within coefficient and read vectors
  typedef enum logic [2:0] {
    PT_CTR = 3'd0,
    PT_IM  = 3'd1,
    PT_IP  = 3'd2,
    PT_JM  = 3'd3,
    PT_JP  = 3'd4,
    PT_KM  = 3'd5,
    PT_KP  = 3'd6
  } pt_e;

  localparam logic [3:0] REG_EXT_I = 4'd7;
  localparam logic [3:0] REG_EXT_J = 4'd8;
  localparam logic [3:0] REG_EXT_K = 4'd9;
endpackage

// File: rtl/stencil_cfg_regs.sv
module stencil_cfg_regs
  import stencil_pkg::*;
#(
  parameter int W     = 16,
  parameter int DIM_W = 4,
  parameter int MAX_I = 8,
  parameter int MAX_J = 8,
  parameter int MAX_K = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     we,
  input  logic [3:0]               addr,
  input  logic [W-1:0]             wdata,
  input  logic                     idle,
  output logic [NPTS-1:0][W-1:0]   coef,
  output logic [DIM_W-1:0]         ext_i,
  output logic [DIM_W-1:0]         ext_j,
  output logic [DIM_W-1:0]         ext_k
);
  logic [31:0] wd32;
  logic        ok_i, ok_j, ok_k;

  assign wd32 = 32'(wdata);
  assign ok_i = idle && (wd32 != 0) && (wd32 <= 32'(MAX_I));
  assign ok_j = idle && (wd32 != 0) && (wd32 <= 32'(MAX_J));
  assign ok_k = idle && (wd32 != 0) && (wd32 <= 32'(MAX_K));

  for (genvar p = 0; p < NPTS; p++) begin : g_coef
    always_ff @(posedge clk) begin
      if (rst)
        coef[p] <= '0;
      else if (we && addr == 4'(p))
        coef[p] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ext_i <= DIM_W'(MAX_I);
      ext_j <= DIM_W'(MAX_J);
      ext_k <= DIM_W'(MAX_K);
    end else if (we) begin
      if (addr == REG_EXT_I && ok_i) ext_i <= DIM_W'(wdata);
      if (addr == REG_EXT_J && ok_j) ext_j <= DIM_W'(wdata);
      if (addr == REG_EXT_K && ok_k) ext_k <= DIM_W'(wdata);
    end
  end

  // R6: extents never move while a frame is in flight
  assert_ext_frozen_R6: assert property (@(posedge clk) disable iff (rst)
    !idle |=> ($stable(ext_i) && $stable(ext_j) && $stable(ext_k)));
endmodule

// File: rtl/stencil_sample_store.sv
module stencil_sample_store
  import stencil_pkg::*;
#(
  parameter int W      = 16,
  parameter int ADDR_W = 8
) (
  input  logic                        clk,
  input  logic                        we,
  input  logic [ADDR_W-1:0]           waddr,
  input  logic [W-1:0]                wdata,
  input  logic                        re,
  input  logic [NPTS-1:0][ADDR_W-1:0] raddr,
  output logic [NPTS-1:0][W-1:0]      rd
);
  localparam int DEPTH = 1 << ADDR_W;

  // One simple dual-port bank per stencil point, all written alike
  for (genvar b = 0; b < NPTS; b++) begin : g_bank
    logic [W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
      if (re) rd[b] <= mem[raddr[b]];
    end
  end
endmodule

// File: rtl/stencil_issue_ctrl.sv
module stencil_issue_ctrl
  import stencil_pkg::*;
#(
  parameter int DIM_W  = 4,
  parameter int TOT_W  = 10,
  parameter int ADDR_W = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [DIM_W-1:0]            ext_i,
  input  logic [DIM_W-1:0]            ext_j,
  input  logic [DIM_W-1:0]            ext_k,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic                        adv,
  output logic                        wr_en,
  output logic [ADDR_W-1:0]           wr_addr,
  output logic                        issue,
  output logic                        issue_bnd,
  output logic [NPTS-1:0][ADDR_W-1:0] raddr,
  output logic                        idle
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [TOT_W-1:0] n_in, c_idx, plane, total;
  logic [DIM_W-1:0] ci, cj, ck;
  logic             in_done, can_issue, last_cell;
  logic [ADDR_W-1:0] ca, ra, pa;

  assign plane = TOT_W'(ext_i) * TOT_W'(ext_j);
  assign total = plane * TOT_W'(ext_k);

  assign issue_bnd = (ci == '0) || (ci == ext_i - DIM_W'(1)) ||
                     (cj == '0) || (cj == ext_j - DIM_W'(1)) ||
                     (ck == '0) || (ck == ext_k - DIM_W'(1));

  // Face cells need only their centre; interior cells need the K+1 sample
  assign can_issue = issue_bnd ? (n_in > c_idx)
                               : (int'(n_in) > int'(c_idx) + int'(plane));
  assign issue     = adv && can_issue;
  assign last_cell = (c_idx == total - TOT_W'(1));

  assign in_ready = !in_done && ((int'(n_in) - int'(c_idx)) < (DEPTH - int'(plane)));
  assign wr_en    = in_valid && in_ready;
  assign wr_addr  = ADDR_W'(n_in);
  assign idle     = (n_in == '0) && (c_idx == '0) && !in_done;

  assign ca = ADDR_W'(c_idx);
  assign ra = ADDR_W'(ext_i);
  assign pa = ADDR_W'(plane);

  always_comb begin
    raddr[PT_CTR] = ca;
    raddr[PT_IM]  = ca - ADDR_W'(1);
    raddr[PT_IP]  = ca + ADDR_W'(1);
    raddr[PT_JM]  = ca - ra;
    raddr[PT_JP]  = ca + ra;
    raddr[PT_KM]  = ca - pa;
    raddr[PT_KP]  = ca + pa;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      n_in    <= '0;
      in_done <= 1'b0;
      c_idx   <= '0;
      ci      <= '0;
      cj      <= '0;
      ck      <= '0;
    end else begin
      if (wr_en) begin
        n_in <= n_in + TOT_W'(1);
        if (n_in + TOT_W'(1) == total) in_done <= 1'b1;
      end
      if (issue) begin
        if (last_cell) begin
          c_idx   <= '0;
          ci      <= '0;
          cj      <= '0;
          ck      <= '0;
          n_in    <= '0;
          in_done <= 1'b0;
        end else begin
          c_idx <= c_idx + TOT_W'(1);
          if (ci == ext_i - DIM_W'(1)) begin
            ci <= '0;
            if (cj == ext_j - DIM_W'(1)) begin
              cj <= '0;
              ck <= ck + DIM_W'(1);
            end else begin
              cj <= cj + DIM_W'(1);
            end
          end else begin
            ci <= ci + DIM_W'(1);
          end
        end
      end
    end
  end

  // R5: no sample beyond the frame length is ever stored
  assert_frame_bound_R5: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (n_in < total));

  // R5: the write pointer never laps the oldest sample still needed
  assert_window_R5: assert property (@(posedge clk) disable iff (rst)
    (int'(n_in) - int'(c_idx)) <= (DEPTH - int'(plane)));

  // R3: the output cursor stays inside the frame
  assert_cursor_R3: assert property (@(posedge clk) disable iff (rst)
    issue |-> (c_idx < total));
endmodule

// File: rtl/stencil_mac.sv
module stencil_mac
  import stencil_pkg::*;
#(
  parameter int W     = 16,
  parameter int OUT_W = 24,
  parameter int SHIFT = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      out_ready,
  input  logic                      issue,
  input  logic                      issue_bnd,
  input  logic [NPTS-1:0][W-1:0]    rd,
  input  logic [NPTS-1:0][W-1:0]    coef,
  output logic                      adv,
  output logic                      out_valid,
  output logic [OUT_W-1:0]          out_data,
  output logic                      out_boundary
);
  localparam int PW    = 2 * W;
  localparam int ACC_W = PW + 3;

  logic                   v2, b2, v3, b3;
  logic [W-1:0]           ctr3;
  logic [NPTS-1:0][PW-1:0] prod;
  logic signed [ACC_W-1:0] acc;

  assign adv = !out_valid || out_ready;

  always_comb begin
    acc = '0;
    for (int p = 0; p < NPTS; p++)
      acc = acc + ACC_W'($signed(prod[p]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v2        <= 1'b0;
      v3        <= 1'b0;
      out_valid <= 1'b0;
    end else if (adv) begin
      v2        <= issue;
      v3        <= v2;
      out_valid <= v3;
    end
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      b2   <= issue_bnd;
      b3   <= b2;
      ctr3 <= rd[PT_CTR];
      for (int p = 0; p < NPTS; p++)
        prod[p] <= PW'($signed(rd[p]) * $signed(coef[p]));
      out_boundary <= b3;
      out_data     <= b3 ? OUT_W'($signed(ctr3)) : acc[SHIFT +: OUT_W];
    end
  end

  // R4: a stalled result holds still
  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_boundary)));

  // R2: a face result is a sign-extended sample
  assert_bnd_sext_R2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_boundary) |->
      ((out_data[OUT_W-1:W-1] == '0) || (out_data[OUT_W-1:W-1] == '1)));
endmodule

// File: rtl/stencil7_engine.sv
module stencil7_engine
  import stencil_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int OUT_W    = 24,
  parameter int SHIFT    = 8,
  parameter int MAX_I    = 8,
  parameter int MAX_J    = 8,
  parameter int MAX_K    = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_we,
  input  logic [3:0]          cfg_addr,
  input  logic [SAMPLE_W-1:0] cfg_wdata,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [SAMPLE_W-1:0] in_data,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [OUT_W-1:0]    out_data,
  output logic                out_boundary
);
  localparam int MAX_IJ = (MAX_I > MAX_J) ? MAX_I : MAX_J;
  localparam int MAX_D  = (MAX_IJ > MAX_K) ? MAX_IJ : MAX_K;
  localparam int DIM_W  = $clog2(MAX_D + 1);
  localparam int TOT_W  = $clog2(MAX_I * MAX_J * MAX_K + 1);
  localparam int ADDR_W = $clog2(2 * MAX_I * MAX_J + 2);

  logic [NPTS-1:0][SAMPLE_W-1:0] coef, rd;
  logic [NPTS-1:0][ADDR_W-1:0]   raddr;
  logic [DIM_W-1:0]              ext_i, ext_j, ext_k;
  logic [ADDR_W-1:0]             wr_addr;
  logic                          idle, adv, wr_en, issue, issue_bnd;

  stencil_cfg_regs #(
    .W(SAMPLE_W), .DIM_W(DIM_W), .MAX_I(MAX_I), .MAX_J(MAX_J), .MAX_K(MAX_K)
  ) cfg_u (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .idle(idle), .coef(coef), .ext_i(ext_i), .ext_j(ext_j), .ext_k(ext_k)
  );

  stencil_issue_ctrl #(
    .DIM_W(DIM_W), .TOT_W(TOT_W), .ADDR_W(ADDR_W)
  ) ctrl_u (
    .clk(clk), .rst(rst), .ext_i(ext_i), .ext_j(ext_j), .ext_k(ext_k),
    .in_valid(in_valid), .in_ready(in_ready), .adv(adv),
    .wr_en(wr_en), .wr_addr(wr_addr), .issue(issue), .issue_bnd(issue_bnd),
    .raddr(raddr), .idle(idle)
  );

  stencil_sample_store #(
    .W(SAMPLE_W), .ADDR_W(ADDR_W)
  ) store_u (
    .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(in_data),
    .re(adv), .raddr(raddr), .rd(rd)
  );

  stencil_mac #(
    .W(SAMPLE_W), .OUT_W(OUT_W), .SHIFT(SHIFT)
  ) mac_u (
    .clk(clk), .rst(rst), .out_ready(out_ready), .issue(issue),
    .issue_bnd(issue_bnd), .rd(rd), .coef(coef), .adv(adv),
    .out_valid(out_valid), .out_data(out_data), .out_boundary(out_boundary)
  );
endmodule

// File: tb/stencil7_engine_tb_top.sv
`timescale 1ns/1ps
module stencil7_engine_tb_top;
  localparam int W  = 16;
  localparam int OW = 24;
  localparam int SH = 8;

  logic          clk = 1'b0;
  logic          rst;
  logic          cfg_we;
  logic [3:0]    cfg_addr;
  logic [W-1:0]  cfg_wdata;
  logic          in_valid, in_ready, out_valid, out_ready, out_boundary;
  logic [W-1:0]  in_data;
  logic [OW-1:0] out_data;

  always #4 clk = ~clk;

  stencil7_engine dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_boundary(out_boundary)
  );

  int n_chk = 0;
  int n_bad = 0;
  int di = 8, dj = 8, dk = 8;
  int cf [7];
  logic [OW-1:0] exp_d [$];
  bit            exp_b [$];

  task automatic check(bit ok, string req, string what, longint act, longint expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic write_cfg(int a, int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = W'(d);
    @(negedge clk);
    cfg_we = 1'b0;
    if (a < 7) cf[a] = int'($signed(W'(d)));
    else if (a == 7 && d >= 1 && d <= 8) di = d;
    else if (a == 8 && d >= 1 && d <= 8) dj = d;
    else if (a == 9 && d >= 1 && d <= 8) dk = d;
  endtask

  // Golden model: one entry per cell in raster order
  function automatic void build_expect(int fs[]);
    int p = di * dj;
    for (int c = 0; c < di * dj * dk; c++) begin
      int i = c % di;
      int j = (c / di) % dj;
      int k = c / p;
      bit bnd = (i == 0) || (i == di - 1) || (j == 0) || (j == dj - 1) ||
                (k == 0) || (k == dk - 1);
      logic signed [63:0] a;
      if (bnd) begin
        a = longint'(fs[c]);
        exp_d.push_back(a[OW-1:0]);
      end else begin
        a = longint'(cf[0]) * fs[c]     + longint'(cf[1]) * fs[c-1]  +
            longint'(cf[2]) * fs[c+1]   + longint'(cf[3]) * fs[c-di] +
            longint'(cf[4]) * fs[c+di]  + longint'(cf[5]) * fs[c-p]  +
            longint'(cf[6]) * fs[c+p];
        exp_d.push_back(a[SH+OW-1:SH]);
      end
      exp_b.push_back(bnd);
    end
  endfunction

  function automatic void make_frame(ref int fs[], input int mode);
    fs = new[di * dj * dk];
    foreach (fs[n]) fs[n] = (mode == 1) ? -32768 : int'($signed(16'($urandom())));
  endfunction

  // Streams samples, compares every result as it is taken
  task automatic run_stream(int fs[], int gap, int bp, int poke);
    int idx = 0, got = 0, cyc = 0, extra = 0;
    int want = exp_d.size();
    bit hold = 0;
    logic [OW-1:0] hd;
    bit hb;
    while (got < want) begin
      @(negedge clk);
      if (hold) check(out_valid && out_data == hd && out_boundary == hb,
                      "R4", "stalled result moved", longint'(out_data), longint'(hd));
      cfg_we = 1'b0;
      if (cyc == poke) begin
        cfg_we = 1'b1; cfg_addr = 4'd7; cfg_wdata = 16'd3;
      end
      in_valid = (idx < fs.size()) && ($urandom_range(99) >= gap);
      in_data  = (idx < fs.size()) ? W'(fs[idx]) : '0;
      out_ready = ($urandom_range(99) >= bp);
      #1;
      if (in_valid && in_ready) idx++;
      hold = out_valid && !out_ready;
      hd = out_data; hb = out_boundary;
      if (out_valid && out_ready) begin
        logic [OW-1:0] ed = exp_d.pop_front();
        bit eb = exp_b.pop_front();
        check(out_data == ed, eb ? "R2" : "R1", "result value",
              longint'($signed(out_data)), longint'($signed(ed)));
        check(out_boundary == eb, "R2", "boundary flag", longint'(out_boundary), longint'(eb));
        got++;
      end
      cyc++;
    end
    @(negedge clk);
    cfg_we = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
    repeat (12) begin
      @(negedge clk);
      if (out_valid) extra++;
    end
    check(extra == 0, "R3", "results beyond frame", extra, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R3 watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int fa[], fb[], fab[];
    foreach (cf[n]) cf[n] = 0;
    rst = 1'b1; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    in_valid = 1'b0; in_data = '0; out_ready = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R7", "out_valid after reset", out_valid, 0);
    check(in_ready == 1'b1, "R7", "in_ready after reset", in_ready, 1);

    // R7: default 8x8x8 extents and zero coefficients
    make_frame(fa, 0); build_expect(fa); run_stream(fa, 0, 0, -1);

    // R1 R2 R3: 6x5x4 grid, random coefficients and data
    write_cfg(7, 6); write_cfg(8, 5); write_cfg(9, 4);
    for (int p = 0; p < 7; p++) write_cfg(p, int'($urandom_range(65535)));
    make_frame(fa, 0); build_expect(fa); run_stream(fa, 0, 0, -1);

    // R4: input gaps and heavy output backpressure
    make_frame(fa, 0); build_expect(fa); run_stream(fa, 30, 60, -1);
    make_frame(fa, 0); build_expect(fa); run_stream(fa, 0, 85, -1);

    // R9: every sample and coefficient at the negative extreme
    for (int p = 0; p < 7; p++) write_cfg(p, 16'h8000);
    make_frame(fa, 1); build_expect(fa); run_stream(fa, 0, 0, -1);

    // R5: two frames back to back
    for (int p = 0; p < 7; p++) write_cfg(p, int'($urandom_range(65535)));
    make_frame(fa, 0); make_frame(fb, 0);
    build_expect(fa); build_expect(fb);
    fab = new[fa.size() + fb.size()];
    foreach (fa[n]) fab[n] = fa[n];
    foreach (fb[n]) fab[fa.size() + n] = fb[n];
    run_stream(fab, 0, 20, -1);

    // R6 R8: out-of-range, busy and unmapped writes are dropped
    write_cfg(7, 0); write_cfg(8, 9); write_cfg(12, 16'h1234); write_cfg(15, 16'h0001);
    make_frame(fa, 0); build_expect(fa); run_stream(fa, 0, 10, 6);

    // R10: a K extent of 2 puts every cell on a face
    write_cfg(7, 4); write_cfg(8, 3); write_cfg(9, 2);
    make_frame(fa, 0); build_expect(fa); run_stream(fa, 10, 30, -1);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule